// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs one clause-22 management transaction on the MDC/MDIO pins for every 32-bit command word that software writes. The command word is laid out so that it already contains the start code, the opcode, the PHY and register addresses, the turnaround code and, for writes, the 16 data bits. The controller sends a preamble of ones and then shifts the word out as it stands. It derives MDC from the system clock with one of two selectable division ratios.

On a read command, the controller stops driving the line at the second turnaround bit. It then samples the sixteen data bits that the PHY returns and writes them into the low half of the same command word, where software reads them back. An idle flag shows whether a new command can be accepted. Commands are taken only while the port enable is high and no transaction is running.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `mgmt_idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is all zeros.
- R2: A `cmd_we` pulse sampled while `mgmt_idle` is 1 and `mgmt_en` is 1 starts a transaction. In the following cycle `mgmt_idle` is 0 and `cmd_rdata` holds the written word.
- R3: A `cmd_we` pulse sampled while a transaction is running is ignored. `cmd_rdata` then ends that transaction with the first word, and no second transaction follows.
- R4: A `cmd_we` pulse sampled while `mgmt_en` is 0 is ignored. `mgmt_idle` stays 1, `mdc` stays low and `cmd_rdata` is unchanged.
- R5: While a transaction runs, one MDC period lasts DIV_LO clock cycles when `div_sel` was 0 at the write, and DIV_HI cycles when it was 1. Each period starts with its low half. While idle, `mdc` is held low.
- R6: Each transaction begins with PRE_LEN (32) MDC cycles in which MDIO is driven to 1.
- R7: After the preamble, the 32 command bits appear on MDIO most significant bit first, one bit per MDC cycle, and each is valid at the rising MDC edge. Bits [29:28] hold the opcode. A write command (opcode 01) drives every bit, including the data in [15:0].
- R8: For a read command (opcode 10), `mdio_oe` stays 1 up to and including word bit 17 (the first turnaround bit). It is 0 from word bit 16 (the second turnaround bit) to the end of the frame.
- R9: For a read, the controller samples `mdio_i` on the rising MDC edges of the final 16 frame bits, most significant bit first. When the transaction ends, these bits replace `cmd_rdata[15:0]`, and `cmd_rdata[31:16]` keeps the written value.
- R10: `mgmt_idle` returns to 1 after exactly PRE_LEN+32 MDC cycles, and `mdio_oe` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word: start, opcode, addresses, turnaround, data |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | MDC ratio select: 0 selects DIV_LO, 1 selects DIV_HI |
| mdio_i | input | 1 | MDIO level sampled from the pin |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO level to drive |
| mdio_oe | output | 1 | MDIO output enable |
| cmd_rdata | output | 32 | Command word readback, with read data in [15:0] |
| mgmt_idle | output | 1 | 1 when a new command can be accepted |

## Verification
The bench builds the block with DIV_LO=4 and DIV_HI=6, keeping the default 32-cycle preamble. With these small even ratios, a full 64-bit-time frame finishes in a few hundred clocks, so both ratios, reads and writes can be run back to back. The low half and high half of MDC stay distinct, so each measured period shows which ratio was selected. A PHY model in the bench drives the turnaround zero and the data bits, which checks the release point and the sample order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } mdio_phase_e;

    localparam int          CMD_W  = 32;
    localparam int          DATA_W = 16;
    localparam logic [1:0]  OP_RD  = 2'b10;
    localparam logic [1:0]  OP_WR  = 2'b01;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_LO = 32,
    parameter int DIV_HI = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW   = $clog2(DMAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t d, q;
    logic [CW-1:0] per_m1;
    logic [CW-1:0] half_m1;

    assign per_m1  = sel ? CW'(DIV_HI - 1)     : CW'(DIV_LO - 1);
    assign half_m1 = sel ? CW'(DIV_HI / 2 - 1) : CW'(DIV_LO / 2 - 1);

    assign rise_evt = run && (q.cnt == half_m1);
    assign fall_evt = run && (q.cnt == per_m1);
    assign mdc      = q.mdc;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (fall_evt) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (rise_evt) d.mdc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mdio_shift_in.sv
module mdio_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)     val_d = '0;
        else if (en) val_d = {val_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              mgmt_en,
    input  logic              div_sel,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic [DATA_W-1:0] cap_val,
    output logic              busy,
    output logic              sel_out,
    output logic              mdo,
    output logic              mdo_en,
    output logic [CMD_W-1:0]  word,
    output logic              cap_clr,
    output logic              cap_en
);
    localparam int TOTAL       = PRE_LEN + CMD_W;
    localparam int PW          = $clog2(TOTAL);
    localparam int OP_HI       = CMD_W - 3;
    localparam int OP_LO       = CMD_W - 4;
    localparam logic [PW-1:0] LAST_POS    = PW'(TOTAL - 1);
    localparam logic [PW-1:0] FRAME_POS   = PW'(PRE_LEN);
    localparam logic [PW-1:0] RELEASE_POS = PW'(PRE_LEN + CMD_W - DATA_W - 1);
    localparam logic [PW-1:0] CAP_POS     = PW'(PRE_LEN + CMD_W - DATA_W);

    typedef struct packed {
        mdio_phase_e      phase;
        logic [PW-1:0]    pos;
        logic [CMD_W-1:0] word;
        logic [CMD_W-1:0] shreg;
        logic             sel;
        logic             is_rd;
        logic             mdo;
        logic             oe;
    } seq_t;

    seq_t d, q;
    logic accept;

    always_comb begin
        d      = q;
        accept = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (cmd_we && mgmt_en) begin
                    accept  = 1'b1;
                    d.phase = PH_PRE;
                    d.pos   = '0;
                    d.word  = cmd_wdata;
                    d.shreg = cmd_wdata;
                    d.sel   = div_sel;
                    d.is_rd = (cmd_wdata[OP_HI:OP_LO] == OP_RD);
                    d.mdo   = 1'b1;
                    d.oe    = 1'b1;
                end
            end
            default: begin
                if (fall_evt) begin
                    if (q.pos == LAST_POS) begin
                        d.phase = PH_IDLE;
                        d.mdo   = 1'b1;
                        d.oe    = 1'b0;
                        if (q.is_rd) d.word[DATA_W-1:0] = cap_val;
                    end else begin
                        d.pos = q.pos + 1'b1;
                        if (d.pos >= FRAME_POS) begin
                            d.phase = PH_FRAME;
                            d.mdo   = q.shreg[CMD_W-1];
                            d.shreg = {q.shreg[CMD_W-2:0], 1'b0};
                            d.oe    = !(q.is_rd && (d.pos >= RELEASE_POS));
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.mdo   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.phase != PH_IDLE);
    assign sel_out = q.sel;
    assign mdo     = q.mdo;
    assign mdo_en  = q.oe;
    assign word    = q.word;
    assign cap_clr = accept;
    assign cap_en  = rise_evt && q.is_rd && (q.phase == PH_FRAME) && (q.pos >= CAP_POS);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_LO  = 32,
    parameter int DIV_HI  = 48,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    input  logic        mgmt_en,
    input  logic        div_sel,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [31:0] cmd_rdata,
    output logic        mgmt_idle
);
    logic              busy;
    logic              sel_l;
    logic              rise_evt;
    logic              fall_evt;
    logic              cap_clr;
    logic              cap_en;
    logic [DATA_W-1:0] cap_val;

    mdio_clkdiv #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sel      (sel_l),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_seq #(
        .PRE_LEN (PRE_LEN)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .mgmt_en   (mgmt_en),
        .div_sel   (div_sel),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .cap_val   (cap_val),
        .busy      (busy),
        .sel_out   (sel_l),
        .mdo       (mdio_o),
        .mdo_en    (mdio_oe),
        .word      (cmd_rdata),
        .cap_clr   (cap_clr),
        .cap_en    (cap_en)
    );

    mdio_shift_in #(
        .W (DATA_W)
    ) i_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap_clr),
        .en    (cap_en),
        .din   (mdio_i),
        .val   (cap_val)
    );

    assign mgmt_idle = !busy;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [31:0] cmd_wdata,
    input logic        mgmt_en,
    input logic        mdc,
    input logic        mdio_oe,
    input logic [31:0] cmd_rdata,
    input logic        mgmt_idle
);
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_idle && mgmt_en && cmd_we) |=> (!mgmt_idle && cmd_rdata == $past(cmd_wdata))); // R2

    AST_BUSY_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_idle |=> $stable(cmd_rdata[31:16])); // R3

    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_idle && !mgmt_en) |=> mgmt_idle); // R4

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_idle |-> !mdc); // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_idle |-> !mdio_oe); // R10
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .mgmt_en   (mgmt_en),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .cmd_rdata (cmd_rdata),
    .mgmt_idle (mgmt_idle)
);

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;
    localparam int DLO = 4;
    localparam int DHI = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        mgmt_en = 1'b1;
    logic        div_sel = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, mgmt_idle;
    logic [31:0] cmd_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    mdio_mgmt_ctrl #(.DIV_LO(DLO), .DIV_HI(DHI)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .mgmt_en(mgmt_en), .div_sel(div_sel), .mdio_i(mdio_i), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_rdata(cmd_rdata), .mgmt_idle(mgmt_idle)
    );

    always #5 clk = ~clk;

    // {sel, op, phy, reg, data, reply}
    localparam logic [44:0] VEC [6] = '{
        {1'b0, 2'b01, 5'd3,  5'd1,  16'hABCD, 16'h0000},
        {1'b0, 2'b10, 5'd31, 5'd2,  16'h0000, 16'h1234},
        {1'b1, 2'b10, 5'd0,  5'd31, 16'hFFFF, 16'hA55A},
        {1'b1, 2'b01, 5'd17, 5'd0,  16'h0001, 16'h0000},
        {1'b0, 2'b10, 5'd21, 5'd10, 16'h0000, 16'hFFFF},
        {1'b1, 2'b10, 5'd1,  5'd1,  16'h5555, 16'h0001}
    };

    // PHY model and monitor
    int          mon_pos = 0;
    logic [63:0] mon_bits = '0;
    int          mon_oe_err = 0;
    realtime     t0, t1;
    logic        phy_rd = 1'b0;
    logic [15:0] phy_reply = '0;

    always @(posedge mdc) begin
        if (mon_pos == 0) t0 = $realtime;
        if (mon_pos == 1) t1 = $realtime;
        mon_bits = {mon_bits[62:0], mdio_o};
        if (mdio_oe !== !(phy_rd && mon_pos >= 47)) mon_oe_err++;
        mon_pos++;
    end

    always @(negedge mdc) begin
        #1;
        if (phy_rd && mon_pos == 47)                     mdio_i = 1'b0;
        else if (phy_rd && mon_pos >= 48 && mon_pos < 64) mdio_i = phy_reply[63 - mon_pos];
        else                                             mdio_i = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (!mgmt_idle) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] w, input logic s);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = w; div_sel = s;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle", {63'd0, mgmt_idle}, 64'd1);
        chk("R1 mdc", {63'd0, mdc}, 64'd0);
        chk("R1 oe", {63'd0, mdio_oe}, 64'd0);
        chk("R1 rdata", {32'd0, cmd_rdata}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            logic [31:0] w;
            logic        rd;
            w  = {2'b01, VEC[v][43:42], VEC[v][41:37], VEC[v][36:32], 2'b10, VEC[v][31:16]};
            rd = (VEC[v][43:42] == 2'b10);
            phy_rd = rd; phy_reply = VEC[v][15:0];
            mon_pos = 0; mon_oe_err = 0;
            issue(w, VEC[v][44]);
            chk("R2 idle low after accept", {63'd0, mgmt_idle}, 64'd0);
            chk("R2 word loaded", {32'd0, cmd_rdata}, {32'd0, w});
            wait_idle();
            chk("R10 mdc cycle count", 64'(mon_pos), 64'd64);
            chk("R6 preamble", {32'd0, mon_bits[63:32]}, {32'd0, 32'hFFFF_FFFF});
            chk("R5 mdc period", 64'(int'(t1 - t0)), 64'((VEC[v][44] ? DHI : DLO) * 10));
            if (rd) begin
                chk("R7 read header bits", {49'd0, mon_bits[31:17]}, {49'd0, w[31:17]});
                chk("R8 read release", 64'(mon_oe_err), 64'd0);
                chk("R9 read data", {32'd0, cmd_rdata}, {32'd0, w[31:16], VEC[v][15:0]});
            end else begin
                chk("R7 write frame", {32'd0, mon_bits[31:0]}, {32'd0, w});
                chk("R8 write drives all", 64'(mon_oe_err), 64'd0);
                chk("R7 write word kept", {32'd0, cmd_rdata}, {32'd0, w});
            end
            chk("R10 oe released", {63'd0, mdio_oe}, 64'd0);
        end

        // R3: write while busy is ignored
        phy_rd = 1'b0; mon_pos = 0;
        issue(32'h5012_0077, 1'b0);
        repeat (20) @(negedge clk);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 32'h6FFE_FFFF; div_sel = 1'b1;
        @(negedge clk); cmd_we = 1'b0;
        chk("R3 word unchanged while busy", {32'd0, cmd_rdata}, {32'd0, 32'h5012_0077});
        wait_idle();
        chk("R3 word after", {32'd0, cmd_rdata}, {32'd0, 32'h5012_0077});
        chk("R3 single transaction", 64'(mon_pos), 64'd64);
        repeat (30) @(negedge clk);
        chk("R3 no second transaction", {62'd0, mgmt_idle, mdc}, 64'd2);

        // R4: write while disabled is ignored
        mgmt_en = 1'b0;
        issue(32'h6002_0000, 1'b0);
        chk("R4 idle stays", {63'd0, mgmt_idle}, 64'd1);
        repeat (3 * DHI) @(negedge clk);
        chk("R4 mdc low", {63'd0, mdc}, 64'd0);
        chk("R4 word unchanged", {32'd0, cmd_rdata}, {32'd0, 32'h5012_0077});
        mgmt_en = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule